// File: doc/BRIEF.md
# Sync Polarity Detector

This block works out whether each of two separate video sync inputs, horizontal and vertical, is an active-high or active-low pulse train. It times how long each input stays high and how long it stays low. A level that lasts longer than a "long" threshold is taken as the idle level. A level shorter than a "short" threshold is taken as the pulse. The gap between the two thresholds gives hysteresis, so a waveform with an unclear duty cycle leaves the result unchanged.

All timing is counted in microsecond ticks. The ticks come from a prescaler outside the block and arrive as a one-cycle enable. The two inputs must already be synchronous to the block clock. A composite-mode control makes the horizontal flag report the vertical result. Both flags are plain status outputs.

Top module: `sync_polarity_detector`

## Requirements
- R1: The horizontal flag becomes 0 after a cycle in which hsync is high for strictly more than 7 µs and low for strictly less than 6 µs. A high time of exactly 7 µs does not qualify.
- R2: The horizontal flag becomes 1 after a cycle in which hsync is low for strictly more than 7 µs and high for strictly less than 6 µs.
- R3: The vertical flag becomes 0 after a cycle in which vsync is high for more than 4000 µs and low for less than 2000 µs.
- R4: The vertical flag becomes 1 after a cycle in which vsync is low for more than 4000 µs and high for less than 2000 µs.
- R5: A high/low pair that meets neither rule leaves the flag unchanged. This includes two equal periods and a period of exactly 6 µs where "less than 6" is required.
- R6: While composite_mode is 1, hpol_flag equals vpol_flag. While composite_mode is 0, hpol_flag shows the horizontal result, which the vertical input does not affect.
- R7: The period counters saturate and do not wrap. An hsync high time of 36 µs still counts as long.
- R8: During reset both flags read 0.
- R9: Periods are measured in us_tick pulses, not in clock cycles. With a tick on every other clock, 8 clocks of high count as 4 µs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| us_tick | input | 1 | One-cycle pulse, once per microsecond |
| hsync_in | input | 1 | Horizontal sync, synchronous to clk |
| vsync_in | input | 1 | Vertical sync, synchronous to clk |
| composite_mode | input | 1 | 1: horizontal flag mirrors the vertical result |
| hpol_flag | output | 1 | Horizontal polarity, 1 = positive pulses |
| vpol_flag | output | 1 | Vertical polarity, 1 = positive pulses |

## Verification
The bench probes both edges of each threshold. A 7 µs high time must not count as long, and a 6 µs low time must not count as short; a design using >= or <= would flip the flag in these cases. Ambiguous duty cycles follow a known polarity, so a design without hold behaviour would clear or set the flag there. A 36 µs level would read as short in a design whose counter wraps, and a design that counts clocks instead of ticks would treat a half-rate pulse as long. The composite checks catch a mirror that is missing or stuck.

// File: rtl/spd_pkg.sv
// Shared types and the polarity decision rule for the sync polarity detector.
// Assumes: period lengths are given in microseconds and fit in 32 bits.
package spd_pkg;

    typedef enum logic [1:0] {
        VERDICT_NONE = 2'd0,
        VERDICT_NEG  = 2'd1,
        VERDICT_POS  = 2'd2
    } verdict_e;

    // Apply the long/short thresholds to one measured high/low pair.
    function automatic verdict_e classify(input int unsigned hi_us,
                                          input int unsigned lo_us,
                                          input int unsigned long_us,
                                          input int unsigned short_us);
        if (lo_us > long_us && hi_us < short_us)
            return VERDICT_POS;
        else if (hi_us > long_us && lo_us < short_us)
            return VERDICT_NEG;
        else
            return VERDICT_NONE;
    endfunction

endpackage

// File: rtl/spd_period_meter.sv
// Times the high and low periods of one synchronous level signal in tick units.
// On each edge it latches the period that just ended and restarts the count.
// Once both a high and a low period are known, it pulses pair_ready on every
// edge. The partial level seen right after reset is discarded.
// Assumes: level is already synchronous to clk.
module spd_period_meter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             level,
    output logic [CNT_W-1:0] hi_len,
    output logic [CNT_W-1:0] lo_len,
    output logic             pair_ready
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic             level_d;
    logic             seen_edge;
    logic             have_hi;
    logic             have_lo;
    logic [CNT_W-1:0] count;
    logic             edge_now;

    // Detect a change of level against the previous cycle.
    assign edge_now = (level != level_d);

    // Count ticks per level, latch on edges, flag a complete pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_d    <= 1'b0;
            seen_edge  <= 1'b0;
            have_hi    <= 1'b0;
            have_lo    <= 1'b0;
            count      <= '0;
            hi_len     <= '0;
            lo_len     <= '0;
            pair_ready <= 1'b0;
        end else begin
            level_d    <= level;
            pair_ready <= 1'b0;
            if (edge_now) begin
                count     <= tick ? CNT_W'(1) : '0;
                seen_edge <= 1'b1;
                if (seen_edge) begin
                    if (level_d) begin
                        hi_len     <= count;
                        have_hi    <= 1'b1;
                        pair_ready <= have_lo;
                    end else begin
                        lo_len     <= count;
                        have_lo    <= 1'b1;
                        pair_ready <= have_hi;
                    end
                end
            end else if (tick && count != CNT_MAX) begin
                count <= count + CNT_W'(1);
            end
        end
    end

    // R7: once full, the counter stays full until the next edge
    assert_count_saturates_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!edge_now && count == CNT_MAX) |=> (count == CNT_MAX));

    // A count without a tick cannot advance (R9)
    assert_tick_gates_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!edge_now && !tick) |=> $stable(count));

endmodule

// File: rtl/spd_flag_judge.sv
// Holds one polarity flag and updates it when a complete high/low pair is ready.
// A pair that meets neither threshold rule leaves the flag unchanged.
// Assumes: hi_len/lo_len are stable in the cycle pair_ready is high.
module spd_flag_judge #(
    parameter int CNT_W   = 4,
    parameter int LONG_T  = 7,
    parameter int SHORT_T = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pair_ready,
    input  logic [CNT_W-1:0] hi_len,
    input  logic [CNT_W-1:0] lo_len,
    output logic             flag
);
    import spd_pkg::*;

    verdict_e verdict;

    // Classify the latest pair with the shared rule.
    assign verdict = classify(32'(hi_len), 32'(lo_len), LONG_T, SHORT_T);

    // Update the flag on a positive or negative verdict, otherwise hold it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (pair_ready) begin
            case (verdict)
                VERDICT_POS: flag <= 1'b1;
                VERDICT_NEG: flag <= 1'b0;
                default:     flag <= flag;
            endcase
        end
    end

    // R5: without a new pair the flag does not move
    assert_flag_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !pair_ready |=> $stable(flag));

    // R2 (and R4 on the vertical instance): long low + short high gives 1
    assert_pos_rule_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_ready && 32'(lo_len) > LONG_T && 32'(hi_len) < SHORT_T) |=> flag);

    // R1 (and R3 on the vertical instance): long high + short low gives 0
    assert_neg_rule_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_ready && 32'(hi_len) > LONG_T && 32'(lo_len) < SHORT_T) |=> !flag);

endmodule

// File: rtl/sync_polarity_detector.sv
// Top level: one period meter and one flag judge per sync input. In composite
// mode the horizontal flag shows the vertical result.
// Assumes: hsync_in/vsync_in are synchronous to clk; us_tick pulses once per µs.
module sync_polarity_detector #(
    parameter int H_LONG_US  = 7,
    parameter int H_SHORT_US = 6,
    parameter int V_LONG_US  = 4000,
    parameter int V_SHORT_US = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic us_tick,
    input  logic hsync_in,
    input  logic vsync_in,
    input  logic composite_mode,
    output logic hpol_flag,
    output logic vpol_flag
);
    localparam int H_CNT_W = $clog2(H_LONG_US + 1) + 1;
    localparam int V_CNT_W = $clog2(V_LONG_US + 1) + 1;

    logic [H_CNT_W-1:0] h_hi, h_lo;
    logic [V_CNT_W-1:0] v_hi, v_lo;
    logic               h_ready, v_ready;
    logic               h_flag;

    spd_period_meter #(.CNT_W(H_CNT_W)) u_h_meter (
        .clk(clk), .rst_n(rst_n), .tick(us_tick), .level(hsync_in),
        .hi_len(h_hi), .lo_len(h_lo), .pair_ready(h_ready)
    );

    spd_flag_judge #(.CNT_W(H_CNT_W), .LONG_T(H_LONG_US), .SHORT_T(H_SHORT_US)) u_h_judge (
        .clk(clk), .rst_n(rst_n), .pair_ready(h_ready),
        .hi_len(h_hi), .lo_len(h_lo), .flag(h_flag)
    );

    spd_period_meter #(.CNT_W(V_CNT_W)) u_v_meter (
        .clk(clk), .rst_n(rst_n), .tick(us_tick), .level(vsync_in),
        .hi_len(v_hi), .lo_len(v_lo), .pair_ready(v_ready)
    );

    spd_flag_judge #(.CNT_W(V_CNT_W), .LONG_T(V_LONG_US), .SHORT_T(V_SHORT_US)) u_v_judge (
        .clk(clk), .rst_n(rst_n), .pair_ready(v_ready),
        .hi_len(v_hi), .lo_len(v_lo), .flag(vpol_flag)
    );

    // Select what the horizontal flag reports.
    assign hpol_flag = composite_mode ? vpol_flag : h_flag;

    // R8: a cycle in reset leaves both flags at 0
    assert_reset_clears_R8: assert property (@(posedge clk)
        !rst_n |=> (!hpol_flag && !vpol_flag));

    // R6: the horizontal result ignores vertical activity when not composite
    assert_h_independent_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!composite_mode && !h_ready) |=> (composite_mode || $stable(hpol_flag)));

endmodule

// File: tb/sync_polarity_detector_test.sv
// Directed bench: each task drives one sync scenario and checks its result.
module sync_polarity_detector_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic us_tick = 1'b1;
    logic hsync_in = 1'b0;
    logic vsync_in = 1'b0;
    logic composite_mode = 1'b0;
    logic hpol_flag, vpol_flag;
    logic half_tick = 1'b0;

    int checks = 0;
    int fails = 0;
    int h_lead = 0;
    int v_lead = 0;

    sync_polarity_detector uut (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick),
        .hsync_in(hsync_in), .vsync_in(vsync_in),
        .composite_mode(composite_mode),
        .hpol_flag(hpol_flag), .vpol_flag(vpol_flag)
    );

    always #5 clk = ~clk;

    // Tick generator: every clock, or every other clock in half mode.
    initial begin
        forever begin
            @(negedge clk);
            us_tick <= half_tick ? ~us_tick : 1'b1;
        end
    end

    task automatic check(input string req, input logic actual, input logic expected);
        checks++;
        if (actual !== expected) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", req, actual, expected);
        end
    endtask

    // Drive reps of (high hi cycles, low lo cycles), close with a high edge.
    task automatic drive_wave(input bit is_v, input int hi, input int lo, input int reps);
        for (int r = 0; r < reps; r++) begin
            int first_hi;
            first_hi = (r == 0) ? hi - (is_v ? v_lead : h_lead) : hi;
            if (is_v) vsync_in = 1'b1; else hsync_in = 1'b1;
            repeat (first_hi) @(negedge clk);
            if (is_v) vsync_in = 1'b0; else hsync_in = 1'b0;
            repeat (lo) @(negedge clk);
        end
        if (is_v) vsync_in = 1'b1; else hsync_in = 1'b1;
        repeat (3) @(negedge clk);
        if (is_v) v_lead = 3; else h_lead = 3;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R8 hpol in reset", hpol_flag, 1'b0);
        check("R8 vpol in reset", vpol_flag, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_h_positive;
        drive_wave(1'b0, 3, 12, 3);
        check("R2 hsync positive pulses", hpol_flag, 1'b1);
    endtask

    task automatic t_h_ambiguous;
        drive_wave(1'b0, 6, 6, 3);
        check("R5 equal short periods hold", hpol_flag, 1'b1);
        drive_wave(1'b0, 12, 12, 3);
        check("R5 equal long periods hold", hpol_flag, 1'b1);
        drive_wave(1'b0, 12, 6, 3);
        check("R5 low of exactly 6us holds", hpol_flag, 1'b1);
    endtask

    task automatic t_h_boundary;
        drive_wave(1'b0, 7, 5, 3);
        check("R1 high of exactly 7us is not long", hpol_flag, 1'b1);
        drive_wave(1'b0, 8, 5, 3);
        check("R1 high 8us low 5us gives negative", hpol_flag, 1'b0);
    endtask

    task automatic t_h_negative;
        drive_wave(1'b0, 3, 12, 3);
        check("R2 back to positive", hpol_flag, 1'b1);
        drive_wave(1'b0, 12, 3, 3);
        check("R1 hsync negative pulses", hpol_flag, 1'b0);
    endtask

    task automatic t_half_tick;
        half_tick = 1'b1;
        drive_wave(1'b0, 8, 20, 3);
        check("R9 8 clocks at half tick count as 4us", hpol_flag, 1'b1);
        half_tick = 1'b0;
        @(negedge clk);
        h_lead = h_lead + 1;
    endtask

    task automatic t_saturate;
        drive_wave(1'b0, 36, 3, 3);
        check("R7 36us high still long", hpol_flag, 1'b0);
    endtask

    task automatic t_vertical;
        drive_wave(1'b1, 1000, 4500, 2);
        check("R4 vsync positive pulses", vpol_flag, 1'b1);
        check("R6 hpol unaffected by vsync", hpol_flag, 1'b0);
        drive_wave(1'b1, 4500, 1000, 2);
        check("R3 vsync negative pulses", vpol_flag, 1'b0);
        drive_wave(1'b1, 1000, 4500, 2);
        check("R4 vsync positive again", vpol_flag, 1'b1);
    endtask

    task automatic t_composite;
        check("R6 separate mode shows h result", hpol_flag, 1'b0);
        composite_mode = 1'b1;
        @(negedge clk);
        check("R6 composite mirrors vpol", hpol_flag, 1'b1);
        drive_wave(1'b1, 3000, 3000, 2);
        check("R5 vsync ambiguous holds", vpol_flag, 1'b1);
        check("R6 composite still mirrors", hpol_flag, 1'b1);
        composite_mode = 1'b0;
        @(negedge clk);
        check("R6 separate mode restored", hpol_flag, 1'b0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_h_positive();
        t_h_ambiguous();
        t_h_boundary();
        t_h_negative();
        t_half_tick();
        t_saturate();
        t_vertical();
        t_composite();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule